// File: doc/BRIEF.md
# MMC Host Register and Interrupt Front-End

This block is the register face of an MMC/SD host controller. Software reaches it through a simple word-wide read/write bus. A command/data engine sits behind it and handles the bus signalling, CRC and data movement. The block holds the transfer buffer address, the command argument, the block geometry and the captured response. It turns a write to the command word into decoded fields and a one-cycle start pulse for the engine.

Completion, timeout and card-detect events arrive from the engine and the card socket. Each one sets a sticky status bit, and software clears a bit by writing a one to it. A level interrupt stays high while any status bit is set and its enable bit is set. A timeout marks a failed command, so it suppresses the end-of-command indication. A second command written while one is still outstanding is dropped, and software can see the busy condition in the card-state word.

Top module: `mmc_host_regs`

## Requirements
- R1: Word registers sit at byte offsets 0x00 status, 0x04 enable, 0x08 buffer address, 0x0C command, 0x10 argument, 0x14/0x18/0x1C/0x20 response words 0..3, 0x24 block length, 0x28 block count and 0x2C card state. Offsets beyond 0x2C, and any address with bits 1:0 nonzero, read as zero and ignore writes. Only bits 3:0 of the enable register are kept.
- R2: Status bit 0 is end of command, bit 1 is end of data, bit 2 is card-state change and bit 3 is command timeout. Each is set by its event input and stays set until software clears it.
- R3: Writing the status register clears every bit written as 1 and leaves bits written as 0 alone. When an event sets a bit in the same cycle that a write clears it, the bit stays set.
- R4: `irq` is high exactly while (status AND enable) is nonzero.
- R5: The command word holds opcode in bits 5:0, open-drain in bit 6, response type in bits 9:8 (0 none, 1 R1/R1b, 2 R2, 3 R3), busy-wait in bit 11, command class in bits 13:12 (0 bc, 1 bcr, 2 ac, 3 adtc) and card-to-host read in bit 15. The other bits read as zero. An accepted command write pulses `cmd_start` for one cycle, starting on the clock edge that takes the write, and the decoded fields appear on the engine outputs.
- R6: An accepted command sets busy, which reads in card-state bit 2. Busy clears on end of command or timeout. A command write while busy changes neither the command word nor `cmd_start`.
- R7: A timeout clears a pending end-of-command bit and keeps one that arrives in the same cycle from being set, so only bit 3 is reported.
- R8: Block length and block count store 11 bits each (value minus one), drive `blk_len` and `blk_cnt`, and read back with bits 31:11 zero.
- R9: On `rsp_valid`, response word n captures `rsp_data` bits 32n+31:32n, so word 0 holds bits 31:0 and word 3 holds bits 127:96.
- R10: Card-state bit 0 reflects card inserted and bit 1 write protect. A change in either raises status bit 2 one cycle later. Both are sampled as 0 out of reset.
- R11: Writes to the response words and the card-state register leave them unchanged.
- R12: After reset all registers read zero, `irq` is low and `cmd_start` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Level interrupt |
| cmd_start | output | 1 | One-cycle command launch |
| cmd_opcode | output | 6 | Command opcode |
| cmd_rsp_type | output | 2 | Response type |
| cmd_class | output | 2 | Command class |
| cmd_open_drain | output | 1 | Open-drain signalling |
| cmd_busy_wait | output | 1 | Wait for busy release |
| cmd_read | output | 1 | Card-to-host data |
| cmd_arg | output | 32 | Command argument |
| buf_addr | output | 32 | Transfer buffer address |
| blk_len | output | 11 | Block length minus one |
| blk_cnt | output | 11 | Block count minus one |
| ev_cmd_done | input | 1 | Engine: command finished |
| ev_data_done | input | 1 | Engine: data finished |
| ev_cmd_timeout | input | 1 | Engine: command timed out |
| rsp_valid | input | 1 | Response capture strobe |
| rsp_data | input | 128 | Response bits |
| card_inserted | input | 1 | Card present |
| card_wp | input | 1 | Card write-protected |

## Verification
The hardest cases to reach are the cycle collisions: a timeout landing on the same edge as end of command, and an event landing on the same edge as a write that clears it. The bench reaches them by driving the event inputs and the bus write at the same falling edge, so both are sampled on one rising edge. It also runs the ordered case, where end of command is already set and the timeout follows. It writes the command word while a command is still outstanding and confirms that no start pulse appears and the stored word keeps its value.

// File: rtl/mmc_regs_pkg.sv
package mmc_regs_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned NUM_EV = 4;
  // word indices (byte offset / 4)
  localparam int unsigned IX_STAT  = 0;
  localparam int unsigned IX_EN    = 1;
  localparam int unsigned IX_BUF   = 2;
  localparam int unsigned IX_CMD   = 3;
  localparam int unsigned IX_ARG   = 4;
  localparam int unsigned IX_RSP0  = 5;
  localparam int unsigned IX_BLEN  = 9;
  localparam int unsigned IX_BCNT  = 10;
  localparam int unsigned IX_CARD  = 11;
  // status bit positions
  localparam int unsigned ST_CMD  = 0;
  localparam int unsigned ST_DATA = 1;
  localparam int unsigned ST_CHG  = 2;
  localparam int unsigned ST_TO   = 3;
  // defined command bits
  localparam logic [15:0] CMD_MASK = 16'hBB7F;

  typedef struct packed {
    logic       rd;
    logic       rsv14;
    logic [1:0] cls;
    logic       bsy;
    logic       rsv10;
    logic [1:0] rsp;
    logic       rsv7;
    logic       od;
    logic [5:0] op;
  } cmd_word_t;
endpackage

// File: rtl/mmc_irq_ctrl.sv
module mmc_irq_ctrl
  import mmc_regs_pkg::*;
#(
  parameter int unsigned NEV = NUM_EV
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] set_i,
  input  logic           clr_wr_i,
  input  logic [NEV-1:0] clr_mask_i,
  input  logic           en_wr_i,
  input  logic [NEV-1:0] en_data_i,
  output logic [NEV-1:0] stat_o,
  output logic [NEV-1:0] en_o,
  output logic           irq_o
);
  logic [NEV-1:0] stat_q, en_q, stat_d, clr;

  assign clr = clr_wr_i ? clr_mask_i : '0;

  always_comb begin
    stat_d = (stat_q & ~clr) | set_i;
    if (set_i[ST_TO]) stat_d[ST_CMD] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= stat_d;
      if (en_wr_i) en_q <= en_data_i;
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign irq_o  = |(stat_q & en_q);

  AST_TIMEOUT_HIDES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    set_i[ST_TO] |=> (stat_q[ST_TO] && !stat_q[ST_CMD])); // R7
  AST_DATA_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i[ST_DATA] |=> stat_q[ST_DATA]); // R3
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[ST_DATA] && !clr_wr_i) |=> stat_q[ST_DATA]); // R2
endmodule

// File: rtl/mmc_cmd_launch.sv
module mmc_cmd_launch
  import mmc_regs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_i,
  input  logic [15:0] wdata_i,
  input  logic        done_i,
  output logic [15:0] cmd_o,
  output logic        start_o,
  output logic        busy_o
);
  logic [15:0] cmd_q;
  logic        start_q, busy_q, accept;

  assign accept = wr_i && !busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      start_q <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      start_q <= accept;
      if (accept) begin
        cmd_q  <= wdata_i & CMD_MASK;
        busy_q <= 1'b1;
      end else if (done_i) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign cmd_o   = cmd_q;
  assign start_o = start_q;
  assign busy_o  = busy_q;

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q); // R5
  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> !start_q); // R6
  AST_BUSY_WITH_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> busy_q); // R6
  AST_CMD_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(cmd_q)); // R6
endmodule

// File: rtl/mmc_card_watch.sv
module mmc_card_watch #(
  parameter int unsigned NBITS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] card_i,
  output logic [NBITS-1:0] seen_o,
  output logic             change_o
);
  logic [NBITS-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) seen_q <= '0;
    else        seen_q <= card_i;
  end

  assign seen_o   = seen_q;
  assign change_o = |(card_i ^ seen_q);

  AST_CARD_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    change_o |=> (seen_q != $past(seen_q))); // R10
endmodule

// File: rtl/mmc_rsp_store.sv
module mmc_rsp_store
  import mmc_regs_pkg::*;
#(
  parameter int unsigned NWORDS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     valid_i,
  input  logic [NWORDS*WORD_W-1:0] data_i,
  output logic [NWORDS*WORD_W-1:0] words_o
);
  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    logic [WORD_W-1:0] w_q;
    always_ff @(posedge clk) begin
      if (!rst_n)       w_q <= '0;
      else if (valid_i) w_q <= data_i[g*WORD_W +: WORD_W];
    end
    assign words_o[g*WORD_W +: WORD_W] = w_q;
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(words_o)); // R11
endmodule

// File: rtl/mmc_host_regs.sv
module mmc_host_regs
  import mmc_regs_pkg::*;
#(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned BLK_W     = 11,
  parameter int unsigned RSP_WORDS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_wr,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [WORD_W-1:0]           bus_wdata,
  output logic [WORD_W-1:0]           bus_rdata,
  output logic                        irq,
  output logic                        cmd_start,
  output logic [5:0]                  cmd_opcode,
  output logic [1:0]                  cmd_rsp_type,
  output logic [1:0]                  cmd_class,
  output logic                        cmd_open_drain,
  output logic                        cmd_busy_wait,
  output logic                        cmd_read,
  output logic [WORD_W-1:0]           cmd_arg,
  output logic [WORD_W-1:0]           buf_addr,
  output logic [BLK_W-1:0]            blk_len,
  output logic [BLK_W-1:0]            blk_cnt,
  input  logic                        ev_cmd_done,
  input  logic                        ev_data_done,
  input  logic                        ev_cmd_timeout,
  input  logic                        rsp_valid,
  input  logic [RSP_WORDS*WORD_W-1:0] rsp_data,
  input  logic                        card_inserted,
  input  logic                        card_wp
);
  localparam int unsigned IX_W = ADDR_W - 2;

  logic            aligned;
  logic [IX_W-1:0] ix;
  logic [WORD_W-1:0] buf_q, arg_q;
  logic [BLK_W-1:0]  blen_q, bcnt_q;
  logic [NUM_EV-1:0] stat, en, ev_set;
  logic [15:0]       cmd_raw;
  logic              busy, card_chg;
  logic [1:0]        card_seen;
  logic [RSP_WORDS*WORD_W-1:0] rsp_words;
  cmd_word_t         cw;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign ix      = bus_addr[ADDR_W-1:2];

  function automatic logic hit(input int unsigned idx);
    return bus_wr && aligned && (ix == IX_W'(idx));
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q  <= '0;
      arg_q  <= '0;
      blen_q <= '0;
      bcnt_q <= '0;
    end else begin
      if (hit(IX_BUF))  buf_q  <= bus_wdata;
      if (hit(IX_ARG))  arg_q  <= bus_wdata;
      if (hit(IX_BLEN)) blen_q <= bus_wdata[BLK_W-1:0];
      if (hit(IX_BCNT)) bcnt_q <= bus_wdata[BLK_W-1:0];
    end
  end

  assign ev_set = {ev_cmd_timeout, card_chg, ev_data_done, ev_cmd_done};

  mmc_irq_ctrl #(.NEV(NUM_EV)) u_irq (
    .clk, .rst_n,
    .set_i      (ev_set),
    .clr_wr_i   (hit(IX_STAT)),
    .clr_mask_i (bus_wdata[NUM_EV-1:0]),
    .en_wr_i    (hit(IX_EN)),
    .en_data_i  (bus_wdata[NUM_EV-1:0]),
    .stat_o     (stat),
    .en_o       (en),
    .irq_o      (irq)
  );

  mmc_cmd_launch u_cmd (
    .clk, .rst_n,
    .wr_i    (hit(IX_CMD)),
    .wdata_i (bus_wdata[15:0]),
    .done_i  (ev_cmd_done || ev_cmd_timeout),
    .cmd_o   (cmd_raw),
    .start_o (cmd_start),
    .busy_o  (busy)
  );

  mmc_card_watch #(.NBITS(2)) u_card (
    .clk, .rst_n,
    .card_i   ({card_wp, card_inserted}),
    .seen_o   (card_seen),
    .change_o (card_chg)
  );

  mmc_rsp_store #(.NWORDS(RSP_WORDS)) u_rsp (
    .clk, .rst_n,
    .valid_i (rsp_valid),
    .data_i  (rsp_data),
    .words_o (rsp_words)
  );

  assign cw             = cmd_word_t'(cmd_raw);
  assign cmd_opcode     = cw.op;
  assign cmd_rsp_type   = cw.rsp;
  assign cmd_class      = cw.cls;
  assign cmd_open_drain = cw.od;
  assign cmd_busy_wait  = cw.bsy;
  assign cmd_read       = cw.rd;
  assign cmd_arg        = arg_q;
  assign buf_addr       = buf_q;
  assign blk_len        = blen_q;
  assign blk_cnt        = bcnt_q;

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      if (ix >= IX_W'(IX_RSP0) && ix < IX_W'(IX_RSP0 + RSP_WORDS)) begin
        bus_rdata = rsp_words[(int'(ix) - IX_RSP0)*WORD_W +: WORD_W];
      end else begin
        case (int'(ix))
          IX_STAT: bus_rdata = WORD_W'(stat);
          IX_EN:   bus_rdata = WORD_W'(en);
          IX_BUF:  bus_rdata = buf_q;
          IX_CMD:  bus_rdata = WORD_W'(cmd_raw);
          IX_ARG:  bus_rdata = arg_q;
          IX_BLEN: bus_rdata = WORD_W'(blen_q);
          IX_BCNT: bus_rdata = WORD_W'(bcnt_q);
          IX_CARD: bus_rdata = WORD_W'({busy, card_seen});
          default: bus_rdata = '0;
        endcase
      end
    end
  end

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq); // R4
  AST_START_HAS_ARG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && !hit(IX_ARG)) |=> $stable(cmd_arg)); // R5
endmodule

// File: tb/sim_mmc_host_regs.sv
`timescale 1ns/1ps
module sim_mmc_host_regs;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0;
  logic [5:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq, cmd_start, cmd_open_drain, cmd_busy_wait, cmd_read;
  logic [5:0] cmd_opcode;
  logic [1:0] cmd_rsp_type, cmd_class;
  logic [31:0] cmd_arg, buf_addr;
  logic [10:0] blk_len, blk_cnt;
  logic ev_cmd_done = 0, ev_data_done = 0, ev_cmd_timeout = 0, rsp_valid = 0;
  logic [127:0] rsp_data = 0;
  logic card_inserted = 0, card_wp = 0;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  mmc_host_regs u0 (.*);

  // {do_write, addr, wdata, expected readback}
  localparam int NV = 8;
  localparam logic [70:0] VEC [NV] = '{
    {1'b1, 6'h08, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {1'b1, 6'h10, 32'h0000_1234, 32'h0000_1234},
    {1'b1, 6'h24, 32'hFFFF_FFFF, 32'h0000_07FF},
    {1'b1, 6'h28, 32'h0000_0003, 32'h0000_0003},
    {1'b1, 6'h04, 32'hFFFF_FFF0, 32'h0000_0000},
    {1'b1, 6'h30, 32'h5555_5555, 32'h0000_0000},
    {1'b1, 6'h09, 32'h7777_7777, 32'h0000_0000},
    {1'b0, 6'h08, 32'h0000_0000, 32'hDEAD_BEEF}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse(input logic cd, input logic dd, input logic to);
    @(negedge clk);
    ev_cmd_done = cd; ev_data_done = dd; ev_cmd_timeout = to;
    @(negedge clk);
    ev_cmd_done = 0; ev_data_done = 0; ev_cmd_timeout = 0;
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12 reset state
    check("R12 irq", {31'b0, irq}, 0);
    check("R12 start", {31'b0, cmd_start}, 0);
    rd(6'h00, r); check("R12 status", r, 0);
    rd(6'h0C, r); check("R12 cmd", r, 0);

    // R1 / R8 table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][70]) wr(VEC[i][69:64], VEC[i][63:32]);
      rd(VEC[i][69:64], r);
      check("R1 table", r, VEC[i][31:0]);
    end
    check("R8 blk_len", {21'b0, blk_len}, 32'h7FF);
    check("R8 blk_cnt", {21'b0, blk_cnt}, 3);
    check("R1 buf_addr", buf_addr, 32'hDEAD_BEEF);

    // R5 command launch: op 17, R1, open-drain, busy-wait, adtc, read
    @(negedge clk);
    bus_wr = 1; bus_addr = 6'h0C; bus_wdata = 32'hFFFF_B951;
    @(negedge clk);
    bus_wr = 0;
    check("R5 start pulse", {31'b0, cmd_start}, 1);
    check("R5 fields", {18'b0, cmd_read, cmd_class, cmd_busy_wait, cmd_rsp_type,
                        cmd_open_drain, cmd_opcode},
          {18'b0, 1'b1, 2'd3, 1'b1, 2'd1, 1'b1, 6'd17});
    check("R5 arg", cmd_arg, 32'h1234);
    @(negedge clk);
    check("R5 start one cycle", {31'b0, cmd_start}, 0);
    rd(6'h0C, r); check("R5 cmd readback", r, 32'hB951);
    rd(6'h2C, r); check("R6 busy bit", r, 32'h4);

    // R6 write while busy dropped
    @(negedge clk);
    bus_wr = 1; bus_addr = 6'h0C; bus_wdata = 32'h0000_0005;
    @(negedge clk);
    bus_wr = 0;
    check("R6 no start", {31'b0, cmd_start}, 0);
    rd(6'h0C, r); check("R6 cmd kept", r, 32'hB951);

    // R9 completion with response
    @(negedge clk);
    ev_cmd_done = 1; rsp_valid = 1;
    rsp_data = {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111};
    @(negedge clk);
    ev_cmd_done = 0; rsp_valid = 0;
    rd(6'h14, r); check("R9 word0", r, 32'h1111_1111);
    rd(6'h20, r); check("R9 word3", r, 32'h4444_4444);
    rd(6'h00, r); check("R2 end of cmd", r, 32'h1);
    rd(6'h2C, r); check("R6 busy cleared", r, 0);

    // R4 irq
    check("R4 irq off", {31'b0, irq}, 0);
    wr(6'h04, 32'h1);
    check("R4 irq on", {31'b0, irq}, 1);
    wr(6'h00, 32'h1);
    check("R3 clear", {31'b0, irq}, 0);
    rd(6'h00, r); check("R3 status clear", r, 0);

    // R11 read-only registers
    wr(6'h14, 32'hFFFF_FFFF);
    rd(6'h14, r); check("R11 rsp unchanged", r, 32'h1111_1111);
    wr(6'h2C, 32'hFFFF_FFFF);
    rd(6'h2C, r); check("R11 card unchanged", r, 0);
    rd(6'h00, r); check("R11 no status", r, 0);

    // R7 timeout same cycle as end of command
    wr(6'h0C, 32'h0002);
    pulse(1, 0, 1);
    rd(6'h00, r); check("R7 same cycle", r, 32'h8);
    wr(6'h00, 32'hF);
    // R7 timeout after pending end of command
    wr(6'h0C, 32'h0003);
    pulse(1, 0, 0);
    rd(6'h00, r); check("R7 pending before", r, 32'h1);
    pulse(0, 0, 1);
    rd(6'h00, r); check("R7 pending cancelled", r, 32'h8);
    wr(6'h00, 32'hF);

    // R3 set wins over clear
    wr(6'h00, 32'h0);
    @(negedge clk);
    bus_wr = 1; bus_addr = 6'h00; bus_wdata = 32'h2; ev_data_done = 1;
    @(negedge clk);
    bus_wr = 0; ev_data_done = 0;
    rd(6'h00, r); check("R3 set wins", r, 32'h2);
    wr(6'h00, 32'h1);
    rd(6'h00, r); check("R3 zero bits kept", r, 32'h2);
    wr(6'h00, 32'h2);

    // R10 card detect
    wr(6'h04, 32'h4);
    @(negedge clk); card_inserted = 1;
    @(negedge clk);
    rd(6'h00, r); check("R10 change bit", r, 32'h4);
    check("R10 irq", {31'b0, irq}, 1);
    rd(6'h2C, r); check("R10 inserted", r, 32'h1);
    wr(6'h00, 32'h4);
    @(negedge clk); card_wp = 1;
    @(negedge clk);
    rd(6'h00, r); check("R10 wp change", r, 32'h4);
    rd(6'h2C, r); check("R10 wp bit", r, 32'h3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule